// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers up to 32 interrupt sources into one interrupt line for a processor. Each source is fixed at build time as either level-sensitive or rising-edge-sensitive. Captured events are held in a status register. An enable register masks them, and the result is a pending set. The controller reports the lowest-numbered pending source as a vector and raises its output only when the master output enable is on.

Software reaches the block over a simple word-addressed 32-bit register bus that has a write strobe, a read strobe and registered read data. Software can acknowledge events by writing ones. It can also set or clear enable bits without a read-modify-write sequence. A second master bit turns on hardware capture of the inputs. While that bit is off, software may load the status register directly, for example to raise test interrupts. While it is on, software writes to status are locked out.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all registers read zero, `irq_out` is 0 and the vector register (word 6) reads 0xFFFFFFFF.
- R2: The pending register (word 1) reads status (word 0) AND enable (word 2).
- R3: The vector register holds the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R4: `irq_out` is 1 only when master bit 0 (word 7) is set and at least one pending bit is set. It follows the register state one clock later.
- R5: A write to the acknowledge register (word 3) clears every status bit where the written value has a 1 and leaves the other bits alone.
- R6: A write to word 4 ORs the value into enable. A write to word 5 clears the enable bits that are 1 in the value.
- R7: With master bit 1 at 0, a write to word 0 loads status with the value, and status changes in no other way except through acknowledge. With master bit 1 at 1, a write to word 0 is ignored.
- R8: While master bit 1 is set, a level-sensitive input ORs its pin level into its status bit every cycle. Acknowledging it while the pin is still high leaves the bit set.
- R9: While master bit 1 is set, an edge-sensitive input sets its status bit once per 0-to-1 transition. A pin held high does not set the bit again after acknowledge, and a rising edge while master bit 1 is 0 is lost. With default parameters, inputs 16 to 31 are edge-sensitive and inputs 0 to 15 are level-sensitive.
- R10: Writes to enable and master store the full 32-bit value. Words 3, 4 and 5 read as zero.
- R11: Read data for a read strobe appears on `bus_rdata` in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word index of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Interrupt source pins |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
If the status register holds a wrong bit, the error shows up on the next read of status, pending or vector. It also moves `irq_out` one clock after the register changes. A corrupted enable register shows up the same way, but only for sources whose status bit is set. Edge-detection faults show up only on the cycle after a rising edge, or when a held pin is acknowledged, so the bench drives both held and released pins around acknowledge writes. Vector faults are exposed by pending patterns whose lowest bit sits at index 0, at index 31, in the middle, and with no bit at all.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_STATUS  = 3'd0,
    IDX_PENDING = 3'd1,
    IDX_ENABLE  = 3'd2,
    IDX_ACK     = 3'd3,
    IDX_EN_SET  = 3'd4,
    IDX_EN_CLR  = 3'd5,
    IDX_VECTOR  = 3'd6,
    IDX_MASTER  = 3'd7
  } reg_idx_e;

  localparam int MST_OUT_BIT = 0;
  localparam int MST_CAP_BIT = 1;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pins,
  input  logic             cap_en,
  input  logic             sw_load,
  input  logic [N_SRC-1:0] sw_value,
  input  logic [N_SRC-1:0] ack_bits,
  output logic [N_SRC-1:0] status
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] event_v;
  logic [N_SRC-1:0] stat_d;
  logic [N_SRC-1:0] stat_q;

  // Per-source choice of event: registered rising edge or raw level.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign event_v[i] = pins[i] & ~prev_q[i];
    end else begin : g_level
      assign event_v[i] = pins[i];
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (sw_load && !cap_en) stat_d = sw_value;
    stat_d = stat_d & ~ack_bits;
    if (cap_en) stat_d = stat_d | event_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pins;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] index
);
  always_comb begin
    found = 1'b0;
    index = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        index = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  irq_in,
  output logic              irq_out
);
  logic [N_SRC-1:0]  en_q;
  logic [DATA_W-1:0] mst_q;
  logic [N_SRC-1:0]  status;
  logic [N_SRC-1:0]  pending;
  logic              any_pend;
  logic [IDX_W-1:0]  low_idx;
  logic [DATA_W-1:0] vector;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic              wr_stat;
  logic              wr_ack;

  assign wr_stat = bus_wr && (bus_addr == IDX_STATUS);
  assign wr_ack  = bus_wr && (bus_addr == IDX_ACK);

  irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .pins     (irq_in),
    .cap_en   (mst_q[MST_CAP_BIT]),
    .sw_load  (wr_stat),
    .sw_value (bus_wdata[N_SRC-1:0]),
    .ack_bits (wr_ack ? bus_wdata[N_SRC-1:0] : '0),
    .status   (status)
  );

  assign pending = status & en_q;

  irqc_lowest #(.N_SRC(N_SRC)) u_lowest (
    .req   (pending),
    .found (any_pend),
    .index (low_idx)
  );

  assign vector = any_pend ? DATA_W'(low_idx) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      mst_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        IDX_ENABLE: en_q  <= bus_wdata[N_SRC-1:0];
        IDX_EN_SET: en_q  <= en_q | bus_wdata[N_SRC-1:0];
        IDX_EN_CLR: en_q  <= en_q & ~bus_wdata[N_SRC-1:0];
        IDX_MASTER: mst_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= mst_q[MST_OUT_BIT] && any_pend;
      if (bus_rd) begin
        case (bus_addr)
          IDX_STATUS:  rdata_q <= DATA_W'(status);
          IDX_PENDING: rdata_q <= DATA_W'(pending);
          IDX_ENABLE:  rdata_q <= DATA_W'(en_q);
          IDX_VECTOR:  rdata_q <= vector;
          IDX_MASTER:  rdata_q <= mst_q;
          default:     rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int          N_SRC     = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_SRC-1:0]  irq_in,
  input logic              irq_out,
  input logic [N_SRC-1:0]  status,
  input logic [N_SRC-1:0]  en_q,
  input logic [DATA_W-1:0] mst_q
);
  localparam logic [N_SRC-1:0] LVL = ~EDGE_MASK[N_SRC-1:0];

  p_out_gate_r4: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(mst_q[MST_OUT_BIT]) && ($past(status & en_q) != '0));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == IDX_ACK) |=> ((status & ~EDGE_MASK[N_SRC-1:0] & ~$past(irq_in))
      & $past(bus_wdata[N_SRC-1:0])) == '0 || $past(mst_q[MST_CAP_BIT]) ? 1'b1 :
      ((status & $past(bus_wdata[N_SRC-1:0])) == '0));

  p_en_set_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == IDX_EN_SET) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == IDX_EN_CLR) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!mst_q[MST_CAP_BIT] && !bus_wr) |=> $stable(status));

  p_level_r8: assert property (@(posedge clk) disable iff (rst)
    mst_q[MST_CAP_BIT] |=> ((status & LVL & $past(irq_in)) == (LVL & $past(irq_in))));
endmodule

bind irq_vector_ctrl irqc_checker #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_irqc_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_in    (irq_in),
  .irq_out   (irq_out),
  .status    (status),
  .en_q      (en_q),
  .mst_q     (mst_q)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // {status, enable, pending, vector}
  localparam logic [127:0] VEC_TAB [7] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_0004},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_001F},
    {32'hF0F0_0000, 32'h0F0F_F000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0006, 32'h0000_0004, 32'h0000_0004, 32'h0000_0002},
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    {32'hAAAA_AAAA, 32'h5555_FFFC, 32'h0000_AAA8, 32'h0000_0003}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), r);
      check(a == 6 ? "R1 vector" : "R1 reg zero", r, a == 6 ? 32'hFFFF_FFFF : 32'd0);
    end

    // Table: software-loaded status with capture off, output enabled
    wr_reg(3'd7, 32'h0000_0001);
    for (int k = 0; k < 7; k++) begin
      wr_reg(3'd0, VEC_TAB[k][127:96]);
      wr_reg(3'd2, VEC_TAB[k][95:64]);
      rd_reg(3'd0, r); check("R7 status load", r, VEC_TAB[k][127:96]);
      rd_reg(3'd1, r); check("R2 pending", r, VEC_TAB[k][63:32]);
      rd_reg(3'd6, r); check("R3 vector", r, VEC_TAB[k][31:0]);
      check("R4 irq_out", {31'd0, irq_out}, {31'd0, VEC_TAB[k][63:32] != 0});
    end

    // R4: master bit 0 clear blocks output despite pending
    wr_reg(3'd7, 32'h0000_0000);
    idle(1);
    check("R4 master gate", {31'd0, irq_out}, 32'd0);
    wr_reg(3'd7, 32'h0000_0001);
    idle(1);
    check("R4 master on", {31'd0, irq_out}, 32'd1);

    // R5 acknowledge clears selected bits only
    wr_reg(3'd0, 32'h0000_00F0);
    wr_reg(3'd3, 32'h0000_0030);
    rd_reg(3'd0, r); check("R5 ack", r, 32'h0000_00C0);

    // R6 atomic enable set and clear; R10 full store and write-only reads
    wr_reg(3'd2, 32'h1234_5678);
    rd_reg(3'd2, r); check("R10 enable store", r, 32'h1234_5678);
    wr_reg(3'd4, 32'h8000_0001);
    rd_reg(3'd2, r); check("R6 set-enable", r, 32'h9234_5679);
    wr_reg(3'd5, 32'h1200_0078);
    rd_reg(3'd2, r); check("R6 clear-enable", r, 32'h8034_5601);
    rd_reg(3'd4, r); check("R10 set-enable reads 0", r, 32'd0);
    rd_reg(3'd5, r); check("R10 clear-enable reads 0", r, 32'd0);
    rd_reg(3'd3, r); check("R10 ack reads 0", r, 32'd0);
    wr_reg(3'd7, 32'hA5A5_0001);
    rd_reg(3'd7, r); check("R10 master store", r, 32'hA5A5_0001);

    // R7 lockout of status writes with capture on
    wr_reg(3'd7, 32'h0000_0000);
    wr_reg(3'd0, 32'h0000_0000);
    wr_reg(3'd7, 32'h0000_0002);
    wr_reg(3'd0, 32'h0000_0005);
    rd_reg(3'd0, r); check("R7 lockout", r, 32'd0);

    // R9 edge lost while capture off, not recovered when held high
    wr_reg(3'd7, 32'h0000_0000);
    @(negedge clk); irq_in[20] = 1'b1;
    idle(2);
    wr_reg(3'd7, 32'h0000_0003);
    idle(2);
    rd_reg(3'd0, r); check("R9 edge while off lost", r, 32'd0);
    @(negedge clk); irq_in[20] = 1'b0;
    idle(2);

    // R8 level source re-sets after acknowledge while held
    wr_reg(3'd2, 32'hFFFF_FFFF);
    @(negedge clk); irq_in[3] = 1'b1;
    idle(2);
    rd_reg(3'd0, r); check("R8 level capture", r, 32'h0000_0008);
    wr_reg(3'd3, 32'h0000_0008);
    rd_reg(3'd0, r); check("R8 level held after ack", r, 32'h0000_0008);
    rd_reg(3'd6, r); check("R3 vector level", r, 32'd3);
    @(negedge clk); irq_in[3] = 1'b0;
    wr_reg(3'd3, 32'h0000_0008);
    rd_reg(3'd0, r); check("R8 level clears when low", r, 32'd0);
    idle(1);
    check("R4 irq drops", {31'd0, irq_out}, 32'd0);

    // R9 edge source sets once per rising edge
    @(negedge clk); irq_in[20] = 1'b1;
    idle(2);
    rd_reg(3'd0, r); check("R9 edge capture", r, 32'h0010_0000);
    check("R4 irq edge", {31'd0, irq_out}, 32'd1);
    wr_reg(3'd3, 32'h0010_0000);
    idle(2);
    rd_reg(3'd0, r); check("R9 held edge no re-set", r, 32'd0);
    @(negedge clk); irq_in[20] = 1'b0;
    @(negedge clk); irq_in[20] = 1'b1;
    idle(2);
    rd_reg(3'd0, r); check("R9 second edge", r, 32'h0010_0000);

    // R11 read data timing: data valid the cycle after the strobe
    @(negedge clk);
    bus_addr = 3'd6; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R11 read latency", bus_rdata, 32'd20);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule